// File: doc/BRIEF.md
# Bus Transaction Retry Controller

This block sequences a single transaction on a serial slave bus. Once started, it asks a frame-send engine for a command frame and reads back the response classification that a separate response checker produces. A good response ends the transaction. A busy slave, a damaged response or a request to resend each starts a recovery sequence made of idle clock bursts and poll frames. The controller stops when it succeeds, runs out of retries, or sees the link go dead. The caller gets a one-cycle completion pulse and a result class.

The engine interface is a request/completion handshake. The controller raises `frame_req_o` for exactly one cycle and holds the frame kind, slave number, expected response length and idle bit count steady. It then waits for `engine_done_i`, which carries the response status on the same cycle. The send and echo delay settings are captured at start and passed through to the engine unchanged for the whole transaction. Frame bit encoding, CRC arithmetic and line timing belong to other blocks.

Top module: `bus_retry_ctrl`

## Requirements
- R1: A start pulse while idle raises `busy_o` on the next cycle. It captures slave number, response length, resend wait and both delays. The first frame request is a command (kind 0) carrying the captured response length. Kind codes: 0 command, 1 data-poll, 2 error-poll, 3 terminate, 4 idle clocks.
- R2: A response with good CRC, link alive and code ACK (code 0) on a command or poll frame ends with result OK (0). `done_o` pulses one cycle after the engine completion, and `busy_o` falls on the cycle after that.
- R3: A BUSY code (1) with good CRC triggers idle clock requests totalling DPOLL_CLKS bits, split into chunks of 255 bits except a final remainder. A data-poll frame with the captured response length follows, provided fewer than BUSY_LIM data-polls have been sent for the current command.
- R4: A BUSY code after BUSY_LIM data-polls triggers the idle clocks and then a terminate frame with response length 0. The transaction ends with result IO (1). `term_ok_o` is 1 only if the terminate response has good CRC, link alive and code ACK.
- R5: A failed CRC on a command or poll response triggers idle clocks totalling EPOLL_CLKS bits and then an error-poll frame, while no more than CRC_LIM error-polls have been sent for the current command. A further CRC failure ends with result IO.
- R6: An ERRA code (2) with good CRC ends with result IO and no further frame.
- R7: An ERRC code (3) with good CRC resends the command frame. The request appears W+1 cycles after the completion cycle, where W is the captured resend wait. The busy and CRC counts restart. After RESEND_LIM resends, a further ERRC ends with result IO.
- R8: A link-dead status on a command or poll response ends with result NODEV (2) and no further frame.
- R9: A start pulse while `busy_o` is high is ignored: no extra frame and no extra completion follow.
- R10: `send_dly_o`, `echo_dly_o` and `frame_slave_o` keep their captured values for the whole transaction, even if the inputs change. Responses reported for idle clock requests have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transaction (sampled when idle) |
| slave_i | input | 2 | Target slave number |
| resp_len_i | input | RLEN_W | Response data length in bits for command and polls |
| send_dly_i | input | 8 | Send delay setting for the engine |
| echo_dly_i | input | 8 | Echo delay setting for the engine |
| resend_wait_i | input | GAP_W | Cycles to wait before resending after ERRC |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 OK, 1 IO error, 2 no device |
| term_ok_o | output | 1 | Terminate frame was acknowledged cleanly |
| frame_req_o | output | 1 | One-cycle request to the send engine |
| frame_kind_o | output | 3 | Kind of requested frame |
| frame_slave_o | output | 2 | Captured slave number |
| frame_resp_bits_o | output | RLEN_W | Expected response length for the frame |
| idle_bits_o | output | 8 | Idle zero bits for an idle request, else 0 |
| send_dly_o | output | 8 | Captured send delay |
| echo_dly_o | output | 8 | Captured echo delay |
| engine_done_i | input | 1 | Engine finished the frame; status valid |
| rsp_code_i | input | 2 | Response code: 0 ACK, 1 BUSY, 2 ERRA, 3 ERRC |
| rsp_crc_ok_i | input | 1 | Response CRC good |
| rsp_dead_i | input | 1 | Link appears dead |

## Verification
Every frame request is due on the cycle after the cycle that produced it. The first command request follows the accepted start, and each later request follows the previous engine completion. A resend after ERRC is the exception and comes W further cycles later. `done_o` is due exactly one cycle after the final completion, and `busy_o` falls one cycle after that. The bench drives on falling edges and counts falling edges from each completion to the next request. It compares that count against 0 or W, so any added or missing register stage shows up as a timing failure rather than being absorbed by a wait loop.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam logic [2:0] K_CMD   = 3'd0;
  localparam logic [2:0] K_DPOLL = 3'd1;
  localparam logic [2:0] K_EPOLL = 3'd2;
  localparam logic [2:0] K_TERM  = 3'd3;
  localparam logic [2:0] K_IDLE  = 3'd4;

  localparam logic [1:0] C_ACK  = 2'd0;
  localparam logic [1:0] C_BUSY = 2'd1;
  localparam logic [1:0] C_ERRA = 2'd2;
  localparam logic [1:0] C_ERRC = 2'd3;

  localparam logic [1:0] RES_OK    = 2'd0;
  localparam logic [1:0] RES_IO    = 2'd1;
  localparam logic [1:0] RES_NODEV = 2'd2;

  typedef enum logic [2:0] {
    CL_DEAD, CL_CRC, CL_ACK, CL_BUSY, CL_ERRA, CL_ERRC
  } rsp_class_t;

  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_WAIT, S_GAP, S_DONE
  } brc_state_t;

  // Link loss outranks CRC, CRC outranks the response code.
  function automatic rsp_class_t classify(input logic dead, input logic crc_ok,
                                          input logic [1:0] code);
    if (dead)                classify = CL_DEAD;
    else if (!crc_ok)        classify = CL_CRC;
    else if (code == C_ACK)  classify = CL_ACK;
    else if (code == C_BUSY) classify = CL_BUSY;
    else if (code == C_ERRA) classify = CL_ERRA;
    else                     classify = CL_ERRC;
  endfunction

  function automatic logic clean_ack(input logic dead, input logic crc_ok,
                                     input logic [1:0] code);
    clean_ack = !dead && crc_ok && (code == C_ACK);
  endfunction
endpackage

// File: rtl/brc_limit_ctr.sv
module brc_limit_ctr #(
  parameter int LIM = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_lim_o
);
  localparam int CW = $clog2(LIM + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (inc && !at_lim_o) cnt <= cnt + 1'b1;
  end

  assign at_lim_o = (cnt >= CW'(LIM));
endmodule

// File: rtl/brc_idle_chunker.sv
module brc_idle_chunker #(
  parameter int W         = 9,
  parameter int CHUNK_MAX = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [7:0]   chunk_o,
  output logic         last_o
);
  logic [W-1:0]   rem;
  logic [W+7:0]   rem_ext;

  assign rem_ext = {8'd0, rem};
  assign last_o  = (rem_ext <= (W+8)'(CHUNK_MAX));
  assign chunk_o = last_o ? rem_ext[7:0] : 8'(CHUNK_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rem <= '0;
    else if (load)  rem <= load_val;
    else if (step)  rem <= rem - W'(chunk_o);
  end
endmodule

// File: rtl/brc_gap_timer.sv
module brc_gap_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         expired_o
);
  logic [W-1:0] cnt;

  assign expired_o = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (run && !expired_o) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/bus_retry_ctrl.sv
module bus_retry_ctrl #(
  parameter int RLEN_W     = 6,
  parameter int GAP_W      = 8,
  parameter int BUSY_LIM   = 3,
  parameter int CRC_LIM    = 2,
  parameter int RESEND_LIM = 2,
  parameter int DPOLL_CLKS = 300,
  parameter int EPOLL_CLKS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        slave_i,
  input  logic [RLEN_W-1:0] resp_len_i,
  input  logic [7:0]        send_dly_i,
  input  logic [7:0]        echo_dly_i,
  input  logic [GAP_W-1:0]  resend_wait_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic              term_ok_o,
  output logic              frame_req_o,
  output logic [2:0]        frame_kind_o,
  output logic [1:0]        frame_slave_o,
  output logic [RLEN_W-1:0] frame_resp_bits_o,
  output logic [7:0]        idle_bits_o,
  output logic [7:0]        send_dly_o,
  output logic [7:0]        echo_dly_o,
  input  logic              engine_done_i,
  input  logic [1:0]        rsp_code_i,
  input  logic              rsp_crc_ok_i,
  input  logic              rsp_dead_i
);
  import brc_pkg::*;

  localparam int IDLE_MAX = (DPOLL_CLKS > EPOLL_CLKS) ? DPOLL_CLKS : EPOLL_CLKS;
  localparam int IDLE_W   = $clog2(IDLE_MAX + 1);

  brc_state_t        st;
  logic [2:0]        kind, pending;
  logic [RLEN_W-1:0] rlen;
  logic [GAP_W-1:0]  wait_cfg;

  logic busy_at_lim, crc_at_lim, outer_at_lim, gap_expired;
  logic chunk_last;
  logic [7:0] chunk;

  // Named internal events
  logic       start_acc, fin, is_idle, is_term, ev_eval;
  logic       ev_busy, ev_crc_retry, ev_resend, ev_idle_step;
  rsp_class_t cls;

  assign start_acc    = (st == S_IDLE) && start_i;
  assign fin          = (st == S_WAIT) && engine_done_i;
  assign is_idle      = (kind == K_IDLE);
  assign is_term      = (kind == K_TERM);
  assign ev_eval      = fin && !is_idle && !is_term;
  assign cls          = classify(rsp_dead_i, rsp_crc_ok_i, rsp_code_i);
  assign ev_busy      = ev_eval && (cls == CL_BUSY);
  assign ev_crc_retry = ev_eval && (cls == CL_CRC) && !crc_at_lim;
  assign ev_resend    = ev_eval && (cls == CL_ERRC) && !outer_at_lim;
  assign ev_idle_step = fin && is_idle;

  brc_limit_ctr #(.LIM(BUSY_LIM)) u_busy_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start_acc || ev_resend),
    .inc(ev_busy), .at_lim_o(busy_at_lim));

  brc_limit_ctr #(.LIM(CRC_LIM)) u_crc_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start_acc || ev_resend),
    .inc(ev_crc_retry), .at_lim_o(crc_at_lim));

  brc_limit_ctr #(.LIM(RESEND_LIM)) u_resend_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start_acc),
    .inc(ev_resend), .at_lim_o(outer_at_lim));

  brc_idle_chunker #(.W(IDLE_W), .CHUNK_MAX(255)) u_chunker (
    .clk(clk), .rst_n(rst_n),
    .load(ev_busy || ev_crc_retry),
    .load_val(ev_busy ? IDLE_W'(DPOLL_CLKS) : IDLE_W'(EPOLL_CLKS)),
    .step(ev_idle_step), .chunk_o(chunk), .last_o(chunk_last));

  brc_gap_timer #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n),
    .load(ev_resend && (wait_cfg != '0)),
    .load_val(wait_cfg - 1'b1),
    .run(st == S_GAP), .expired_o(gap_expired));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      kind          <= K_CMD;
      pending       <= K_CMD;
      rlen          <= '0;
      wait_cfg      <= '0;
      frame_slave_o <= '0;
      send_dly_o    <= '0;
      echo_dly_o    <= '0;
      result_o      <= RES_OK;
      term_ok_o     <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (start_i) begin
          frame_slave_o <= slave_i;
          rlen          <= resp_len_i;
          wait_cfg      <= resend_wait_i;
          send_dly_o    <= send_dly_i;
          echo_dly_o    <= echo_dly_i;
          kind          <= K_CMD;
          term_ok_o     <= 1'b0;
          st            <= S_REQ;
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: if (engine_done_i) begin
          if (is_idle) begin
            if (chunk_last) kind <= pending;
            st <= S_REQ;
          end else if (is_term) begin
            term_ok_o <= clean_ack(rsp_dead_i, rsp_crc_ok_i, rsp_code_i);
            result_o  <= RES_IO;
            st        <= S_DONE;
          end else begin
            unique case (cls)
              CL_DEAD: begin result_o <= RES_NODEV; st <= S_DONE; end
              CL_ACK:  begin result_o <= RES_OK;    st <= S_DONE; end
              CL_ERRA: begin result_o <= RES_IO;    st <= S_DONE; end
              CL_CRC: begin
                if (crc_at_lim) begin
                  result_o <= RES_IO; st <= S_DONE;
                end else begin
                  kind <= K_IDLE; pending <= K_EPOLL; st <= S_REQ;
                end
              end
              CL_BUSY: begin
                kind    <= K_IDLE;
                pending <= busy_at_lim ? K_TERM : K_DPOLL;
                st      <= S_REQ;
              end
              default: begin
                if (outer_at_lim) begin
                  result_o <= RES_IO; st <= S_DONE;
                end else begin
                  kind <= K_CMD;
                  st   <= (wait_cfg == '0) ? S_REQ : S_GAP;
                end
              end
            endcase
          end
        end
        S_GAP:  if (gap_expired) st <= S_REQ;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy_o            = (st != S_IDLE);
  assign done_o            = (st == S_DONE);
  assign frame_req_o       = (st == S_REQ);
  assign frame_kind_o      = kind;
  assign idle_bits_o       = is_idle ? chunk : 8'd0;
  assign frame_resp_bits_o = (is_idle || is_term) ? '0 : rlen;
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int RLEN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              frame_req_o,
  input logic [2:0]        frame_kind_o,
  input logic [7:0]        idle_bits_o,
  input logic [RLEN_W-1:0] frame_resp_bits_o,
  input logic [7:0]        send_dly_o,
  input logic [7:0]        echo_dly_o,
  input logic              ev_resend
);
  a_r1_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  a_r1_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req_o |=> !frame_req_o);

  a_r1_req_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    frame_req_o |-> busy_o);

  a_r2_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  a_r3_idle_chunk_range: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req_o && frame_kind_o == 3'd4) |-> (idle_bits_o != 8'd0));

  a_r4_term_no_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req_o && frame_kind_o == 3'd3) |-> (frame_resp_bits_o == '0));

  a_r7_resend_continues: assert property (@(posedge clk) disable iff (!rst_n)
    ev_resend |=> (busy_o && !done_o));

  a_r10_delays_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(send_dly_o) && $stable(echo_dly_o)));
endmodule

bind bus_retry_ctrl brc_checker #(.RLEN_W(RLEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .frame_req_o(frame_req_o), .frame_kind_o(frame_kind_o),
  .idle_bits_o(idle_bits_o), .frame_resp_bits_o(frame_resp_bits_o),
  .send_dly_o(send_dly_o), .echo_dly_o(echo_dly_o), .ev_resend(ev_resend));

// File: tb/sim_bus_retry_ctrl.sv
module sim_bus_retry_ctrl;
  localparam int BL = 3, CL = 2, RL = 2, DP = 300, EP = 50;
  localparam int K_CMD = 0, K_DP = 1, K_EP = 2, K_TERM = 3, K_IDLE = 4;

  logic clk = 0, rst_n = 0;
  logic start_i = 0;
  logic [1:0] slave_i = 0;
  logic [5:0] resp_len_i = 0;
  logic [7:0] send_dly_i = 0, echo_dly_i = 0, resend_wait_i = 0;
  logic busy_o, done_o, term_ok_o, frame_req_o;
  logic [1:0] result_o, frame_slave_o;
  logic [2:0] frame_kind_o;
  logic [5:0] frame_resp_bits_o;
  logic [7:0] idle_bits_o, send_dly_o, echo_dly_o;
  logic engine_done_i = 0, rsp_crc_ok_i = 0, rsp_dead_i = 0;
  logic [1:0] rsp_code_i = 0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [3:0] script[$];
  int cap_slave, cap_len, cap_sd, cap_ed, cap_w;

  always #10 clk = ~clk;

  bus_retry_ctrl #(.RLEN_W(6), .GAP_W(8), .BUSY_LIM(BL), .CRC_LIM(CL),
    .RESEND_LIM(RL), .DPOLL_CLKS(DP), .EPOLL_CLKS(EP)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Response word: {dead, crc_ok, code[1:0]}
  function automatic logic [3:0] rand_rsp();
    int r = $urandom_range(0, 99);
    logic [1:0] c;
    if (r < 50) c = 2'd0; else if (r < 70) c = 2'd1;
    else if (r < 80) c = 2'd2; else c = 2'd3;
    return {($urandom_range(0, 39) == 0), ($urandom_range(0, 5) != 0), c};
  endfunction

  function automatic logic [3:0] next_rsp();
    if (script.size() > 0) return script.pop_front();
    return rand_rsp();
  endfunction

  task automatic respond(input logic [3:0] r);
    repeat ($urandom_range(1, 3)) @(negedge clk);
    start_i = 0;
    engine_done_i = 1; rsp_dead_i = r[3]; rsp_crc_ok_i = r[2]; rsp_code_i = r[1:0];
    @(negedge clk);
    engine_done_i = 0; rsp_dead_i = $urandom_range(0, 1); rsp_code_i = 2'($urandom);
  endtask

  task automatic expect_frame(input int kind, input int bits, input int gap,
                              input string req, input logic [3:0] r);
    int cnt = 0;
    while (!frame_req_o && cnt < 600) begin @(negedge clk); cnt++; end
    chk(frame_req_o, req, 0, 1);
    chk(cnt == gap, req, cnt, gap);
    chk(frame_kind_o == 3'(kind), req, frame_kind_o, kind);
    if (kind == K_IDLE) chk(idle_bits_o == 8'(bits), "R3", idle_bits_o, bits);
    chk(frame_resp_bits_o == 6'((kind == K_IDLE || kind == K_TERM) ? 0 : cap_len),
        "R1", frame_resp_bits_o, (kind == K_IDLE || kind == K_TERM) ? 0 : cap_len);
    chk(frame_slave_o == 2'(cap_slave) && send_dly_o == 8'(cap_sd) &&
        echo_dly_o == 8'(cap_ed), "R10", send_dly_o, cap_sd);
    respond(r);
  endtask

  task automatic idle_burst(input int total, input string req);
    int rem = total;
    while (rem > 0) begin
      int c = (rem > 255) ? 255 : rem;
      expect_frame(K_IDLE, c, 0, req, rand_rsp()); // junk status must be ignored (R10)
      rem -= c;
    end
  endtask

  task automatic run_txn(input int w, input bit poke_start);
    int kind = K_CMD, gap = 0, outer = 0, bc = 0, cc = 0;
    int exp_res = 0, exp_term = 0;
    bit over = 0;
    cap_slave = $urandom_range(0, 3);
    cap_len = 8 * $urandom_range(0, 4);
    cap_sd = $urandom_range(0, 255); cap_ed = $urandom_range(0, 255); cap_w = w;
    slave_i = 2'(cap_slave); resp_len_i = 6'(cap_len);
    send_dly_i = 8'(cap_sd); echo_dly_i = 8'(cap_ed); resend_wait_i = 8'(w);
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o, "R1", busy_o, 1);
    slave_i = ~slave_i; send_dly_i = ~send_dly_i; echo_dly_i = ~echo_dly_i;
    resend_wait_i = 8'($urandom); resp_len_i = ~resp_len_i;
    if (poke_start) start_i = 1; // R9: ignored while busy
    while (!over) begin
      logic [3:0] r = next_rsp();
      expect_frame(kind, 0, gap, kind == K_CMD ? "R7" : "R3", r);
      gap = 0;
      if (kind == K_TERM) begin
        exp_res = 1; exp_term = (!r[3] && r[2] && r[1:0] == 0); over = 1;
      end else if (r[3]) begin
        exp_res = 2; over = 1;                                   // R8
      end else if (!r[2]) begin
        if (cc >= CL) begin exp_res = 1; over = 1; end           // R5
        else begin cc++; idle_burst(EP, "R5"); kind = K_EP; end
      end else case (r[1:0])
        2'd0: begin exp_res = 0; over = 1; end                   // R2
        2'd1: begin                                              // R3 / R4
          idle_burst(DP, "R3");
          if (bc >= BL) kind = K_TERM; else begin bc++; kind = K_DP; end
        end
        2'd2: begin exp_res = 1; over = 1; end                   // R6
        default: begin                                           // R7
          if (outer >= RL) begin exp_res = 1; over = 1; end
          else begin outer++; bc = 0; cc = 0; kind = K_CMD; gap = cap_w; end
        end
      endcase
    end
    chk(done_o == 1, "R2", done_o, 1);
    chk(result_o == 2'(exp_res), exp_res == 2 ? "R8" : "R6", result_o, exp_res);
    if (kind == K_TERM) chk(term_ok_o == 1'(exp_term), "R4", term_ok_o, exp_term);
    @(negedge clk);
    chk(!done_o && !busy_o, "R2", busy_o, 0);
    repeat (3) begin
      @(negedge clk);
      chk(!frame_req_o && !busy_o, "R9", frame_req_o, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !frame_req_o, "R1", busy_o, 0);
    rst_n = 1;
    @(negedge clk);
    script = '{4'b0100};                           run_txn(0, 1); // R2 ACK
    script = '{4'b0101, 4'b0100};                  run_txn(0, 0); // R3 busy then ack
    script = '{4'b0101, 4'b0101, 4'b0101, 4'b0101, 4'b0100}; run_txn(0, 0); // R4 term ok
    script = '{4'b0101, 4'b0101, 4'b0101, 4'b0101, 4'b0000}; run_txn(0, 0); // R4 term bad crc
    script = '{4'b0000, 4'b0000, 4'b0000};         run_txn(0, 0); // R5 limit
    script = '{4'b0010, 4'b0100};                  run_txn(0, 0); // R5 recover
    script = '{4'b0110};                           run_txn(0, 0); // R6
    script = '{4'b0111, 4'b0111, 4'b0111};         run_txn(3, 1); // R7 limit
    script = '{4'b0111, 4'b0100};                  run_txn(0, 0); // R7 W=0
    script = '{4'b1100};                           run_txn(0, 0); // R8
    for (int i = 0; i < 60; i++) run_txn($urandom_range(0, 5), $urandom_range(0, 1));
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule